// File: doc/BRIEF.md
# Leading-Zero-Suppressing BCD Segment Display Decoder

This block turns a row of BCD digits into active-high drive for seven-segment displays, one segment group per digit. Each digit stage decodes its 4-bit code into segments a to g. It also takes a blanking-request input and gives a blanking-request output, so the stages form a chain. The chain runs from the most significant digit down to the least significant. A digit that holds 0 goes dark only while every digit above it is also a suppressed zero. Leading zeros of an integer therefore vanish, and zeros inside the number stay lit.

The block is purely combinational. The wrapper ties the request into the most significant stage high. It ties the request into the least significant stage low, so a value of zero still shows a single 0. Digit k of the input bus occupies bits `[4k+3:4k]`, with digit 0 the least significant. Its segments occupy `segs_o[7k+6:7k]`, with segment a in bit 0, then b, c, d, e and f, and segment g in bit 6.

Top module: `bcd7_zb_display`

## Requirements
- R1: A stage whose code is 0 to 9 and that is not blanked drives these segment patterns (hex, bit 0 = a, bit 6 = g): 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7D, 7→07, 8→7F, 9→6F.
- R2: A code from 10 to 15 turns all seven segments of that digit off and leaves its blanking output low.
- R3: When a stage's blanking input is high and its code is 0, all of its segments are off and its blanking output is high.
- R4: When a stage's blanking input is low, code 0 shows pattern 3F and its blanking output is low.
- R5: A nonzero valid code ignores the blanking input. It shows its R1 pattern and drives its blanking output low.
- R6: The blanking input of the most significant digit is held high, so a 0 in that position is always dark.
- R7: The blanking input of each lower digit k equals the blanking output of digit k+1, and `zbo_o[k]` reports the blanking output of digit k.
- R8: The blanking input of the least significant digit is held low. An all-zero value therefore shows 3F in digit 0 with every other digit dark, and `zbo_o[0]` is always low.
- R9: A zero that has a nonzero digit somewhere above it is displayed as 3F. This applies, for example, to the middle digit of 105.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digits_i | input | 4*NDIGITS | BCD digits, digit 0 in the low nibble |
| segs_o | output | 7*NDIGITS | Segment drive, 7 bits per digit, a in the low bit |
| zbo_o | output | NDIGITS | Blanking output of each digit stage |

## Verification
Two functions can act on one digit in the same evaluation: its own decoding and the blanking request rippling from the stages above. Both are forced together when a 0 sits directly below a run of zeros, when it sits below a nonzero digit, and when it sits below an invalid code. The bench places every code in every position with zeros around it. It also sweeps every integer from 0 to 9999. A reference model walks the chain from the top and predicts, for each digit, whether decoding or blanking wins. That prediction is compared with the segments and blanking outputs.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;

  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;

  // segment bit positions inside one digit group
  localparam int unsigned SEG_A = 0;
  localparam int unsigned SEG_B = 1;
  localparam int unsigned SEG_C = 2;
  localparam int unsigned SEG_D = 3;
  localparam int unsigned SEG_E = 4;
  localparam int unsigned SEG_F = 5;
  localparam int unsigned SEG_G = 6;

  localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK = '0;

endpackage

// File: rtl/bcd7_decode.sv
module bcd7_decode
  import bcd7_pkg::*;
(
  input  bcd_t code_i,
  output seg_t seg_o,
  output logic valid_o
);

  logic lit [SEG_W];

  // each segment is listed by the set of digits that light it
  always_comb begin
    lit[SEG_A] = code_i inside {4'd0, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9};
    lit[SEG_B] = code_i inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd8, 4'd9};
    lit[SEG_C] = code_i inside {4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9};
    lit[SEG_D] = code_i inside {4'd0, 4'd2, 4'd3, 4'd5, 4'd6, 4'd8, 4'd9};
    lit[SEG_E] = code_i inside {4'd0, 4'd2, 4'd6, 4'd8};
    lit[SEG_F] = code_i inside {4'd0, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};
    lit[SEG_G] = code_i inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};
  end

  assign valid_o = (code_i <= BCD_MAX);

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    assign seg_o[s] = lit[s];
  end

  always_comb begin
    if (!valid_o) begin
      AST_INVALID_UNLIT: assert (seg_o == SEG_DARK) else $error("invalid code lights segments"); // R2
    end
  end

endmodule

// File: rtl/bcd7_zb_stage.sv
module bcd7_zb_stage
  import bcd7_pkg::*;
(
  input  bcd_t code_i,
  input  logic zbi_i,
  output seg_t seg_o,
  output logic zbo_o
);

  seg_t raw_seg;
  logic code_valid;
  logic code_zero;
  logic suppress;

  bcd7_decode u_dec (
    .code_i  (code_i),
    .seg_o   (raw_seg),
    .valid_o (code_valid)
  );

  assign code_zero = (code_i == '0);
  assign suppress  = zbi_i & code_zero;
  assign zbo_o     = suppress;
  assign seg_o     = suppress ? SEG_DARK : raw_seg;

  always_comb begin
    if (zbo_o) begin
      AST_BLANK_IS_DARK: assert (seg_o == SEG_DARK) else $error("blanked digit lit"); // R3
    end
    if (code_valid && !zbo_o) begin
      AST_SHOWN_IS_LIT: assert (seg_o != SEG_DARK) else $error("valid digit dark"); // R5
    end
    if (!zbi_i) begin
      AST_NO_REQ_NO_BLANK: assert (!zbo_o) else $error("blank without request"); // R4
    end
  end

endmodule

// File: rtl/bcd7_zb_display.sv
module bcd7_zb_display
  import bcd7_pkg::*;
#(
  parameter int unsigned NDIGITS        = 4,
  parameter bit          KEEP_LAST_ZERO = 1'b1,
  localparam int unsigned IN_W  = BCD_W * NDIGITS,
  localparam int unsigned OUT_W = SEG_W * NDIGITS
) (
  input  logic [IN_W-1:0]    digits_i,
  output logic [OUT_W-1:0]   segs_o,
  output logic [NDIGITS-1:0] zbo_o
);

  // zb_chain[k] is the request entering digit k-1; top entry is the tie-off
  logic [NDIGITS:0]   zb_chain;
  logic [NDIGITS-1:0] zb_in;

  assign zb_chain[NDIGITS] = 1'b1; // R6

  for (genvar k = 0; k < NDIGITS; k++) begin : g_digit
    if (k == 0 && KEEP_LAST_ZERO) begin : g_last
      assign zb_in[k] = 1'b0; // R8
    end else begin : g_mid
      assign zb_in[k] = zb_chain[k+1]; // R7
    end

    bcd7_zb_stage u_stage (
      .code_i (digits_i[k*BCD_W +: BCD_W]),
      .zbi_i  (zb_in[k]),
      .seg_o  (segs_o[k*SEG_W +: SEG_W]),
      .zbo_o  (zb_chain[k])
    );
  end

  assign zbo_o = zb_chain[NDIGITS-1:0];

  always_comb begin
    for (int k = 0; k + 1 < NDIGITS; k++) begin
      if (zbo_o[k] && !(k == 0 && KEEP_LAST_ZERO)) begin
        AST_CHAIN_FROM_ABOVE: assert (zbo_o[k+1]) else $error("blank without blank above"); // R7
      end
    end
    if (KEEP_LAST_ZERO) begin
      AST_LAST_NEVER_BLANK: assert (!zbo_o[0]) else $error("last digit blanked"); // R8
    end
    if (digits_i[IN_W-1 -: BCD_W] == '0) begin
      AST_TOP_ZERO_DARK: assert (segs_o[OUT_W-1 -: SEG_W] == SEG_DARK || (NDIGITS == 1 && KEEP_LAST_ZERO))
        else $error("top zero lit"); // R6
    end
  end

endmodule

// File: tb/bcd7_zb_display_test.sv
`timescale 1ns/1ps
module bcd7_zb_display_test;

  localparam int N = 4;

  logic clk;
  logic [4*N-1:0] digits;
  logic [7*N-1:0] segs;
  logic [N-1:0]   zbo;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [4*N-1:0] q_din[$];
  logic [7*N-1:0] q_seg[$];
  logic [N-1:0]   q_zbo[$];
  string          q_tag[$];

  bcd7_zb_display #(.NDIGITS(N)) uut (
    .digits_i (digits),
    .segs_o   (segs),
    .zbo_o    (zbo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R1 table
  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
      4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
      8: pat = 7'h7F; 9: pat = 7'h6F; default: pat = 7'h00;
    endcase
  endfunction

  // walks the chain from the top digit down
  function automatic void model(input logic [4*N-1:0] d,
                                output logic [7*N-1:0] s, output logic [N-1:0] z);
    logic req;
    req = 1'b1;
    s = '0;
    z = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int v;
      logic rin;
      v = int'(d[k*4 +: 4]);
      rin = (k == 0) ? 1'b0 : req;
      if (v > 9) begin
        s[k*7 +: 7] = 7'h00; z[k] = 1'b0;
      end else if (v == 0 && rin) begin
        s[k*7 +: 7] = 7'h00; z[k] = 1'b1;
      end else begin
        s[k*7 +: 7] = pat(v); z[k] = 1'b0;
      end
      req = z[k];
    end
  endfunction

  task automatic drive(input logic [4*N-1:0] d, input string tag);
    logic [7*N-1:0] es;
    logic [N-1:0] ez;
    model(d, es, ez);
    @(posedge clk);
    #1;
    digits = d;
    q_din.push_back(d);
    q_seg.push_back(es);
    q_zbo.push_back(ez);
    q_tag.push_back(tag);
  endtask

  // monitor: samples on the falling edge, away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_din.size() > 0) begin
        logic [4*N-1:0] d;
        logic [7*N-1:0] es;
        logic [N-1:0] ez;
        string t;
        d = q_din.pop_front();
        es = q_seg.pop_front();
        ez = q_zbo.pop_front();
        t = q_tag.pop_front();
        total++;
        if (segs !== es || zbo !== ez) begin
          bad++;
          $display("FAIL %s digits=%h segs=%h zbo=%b expected segs=%h zbo=%b",
                   t, d, segs, zbo, es, ez);
        end
      end
    end
  end

  initial begin
    digits = '0;
    // reset-like idle state: all zero shows one 0 in digit 0
    drive(16'h0000, "R8 idle");
    drive(16'h0000, "R6 top zero dark");
    // every code in every position, zeros elsewhere
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [4*N-1:0] d;
        d = '0;
        d[p*4 +: 4] = 4'(c);
        if (c > 9)      drive(d, "R2 invalid code");
        else if (p == 0) drive(d, "R4 no request");
        else if (c == 0) drive(d, "R3 blank zero");
        else            drive(d, "R1 R5 pattern");
      end
    end
    // zeros below an invalid code are shown
    drive(16'hA000, "R2 zeros below invalid");
    drive(16'h0F00, "R2 zeros below invalid");
    // embedded zeros
    drive(16'h0105, "R9 embedded zero");
    drive(16'h1000, "R9 trailing zeros");
    drive(16'h0010, "R7 chain");
    // full integer sweep
    for (int v = 0; v < 10000; v++) begin
      logic [4*N-1:0] d;
      d = {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
      drive(d, "R7 R9 sweep");
    end
    wait (q_din.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule